// File: doc/BRIEF.md
# Ratio-Selectable Dual Clock Divider

This block divides one fast source clock into two slower, phase-aligned clocks: a processor clock and a bus clock. A 3-bit select chooses one of seven divide pairs. The pairs give processor-to-bus frequency ratios of 1:1, 4:3, 3:2, 5:3 and 2:1. Each output is made by a counter that toggles a flop every `half` source cycles, so the duty cycle is always 50%.

A common-period counter runs over the least common multiple of the two output periods. Both output counters restart at the boundary of that period, so their rising edges coincide there. A sync pulse marks the first processor-clock period of each common period. The select is sampled only at a boundary, so a change never cuts an output pulse short. The unused select code holds everything low and raises a flag.

Top module: `ratio_clk_gen`

## Requirements
- R1: The select sets the processor divide P (in source cycles) as follows: 000→8, 001→6, 010→4, 011→6, 100→4, 101→6, 110→10.
- R2: The select sets the bus divide B as follows: 000→8, 001→8, 010→6, 011→10, 100→8, 101→6, 110→10. Each output is high for exactly half its divide and low for the other half.
- R3: While rst_ni is low, all four outputs are 0. The first rising clk_i edge after release loads the select, and at that edge both clocks go high together when the select is valid.
- R4: sync_o is high during the first P source cycles of each common period L = lcm(P,B) and low for the rest of it. It rises on the edge where both clocks rise.
- R5: A change of sel_i takes effect only on the first edge after the current common period ends, that is L edges after the last load.
- R6: Select 111 holds pclk_o, bclk_o and sync_o at 0 and drives bad_sel_o to 1. It is re-evaluated on every edge, so a valid select starts output on the next edge.
- R7: bad_sel_o is 0 whenever the loaded select is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| sel_i | input | 3 | Ratio select |
| pclk_o | output | 1 | Processor clock |
| bclk_o | output | 1 | Bus clock |
| sync_o | output | 1 | Common-period marker |
| bad_sel_o | output | 1 | Unsupported select loaded |

## Verification
Every select code is run from reset for several common periods. Each output sample is compared with a cycle model built from the divide table. The three 1:1 pairs differ only in period length, so they catch a swapped table entry that a ratio check alone would miss. Select changes made mid-period, including changes into and out of 111, show whether the new setting waits for the boundary or takes effect too early.

// File: rtl/ratio_clk_pkg.sv
package ratio_clk_pkg;
  localparam int SEL_W  = 3;
  localparam int HALF_W = 3;
  localparam int PER_W  = 5;

  typedef struct packed {
    logic              vld;
    logic [HALF_W-1:0] p_half;
    logic [HALF_W-1:0] b_half;
    logic [PER_W-1:0]  per;
  } ratio_cfg_t;

  function automatic ratio_cfg_t decode_sel(input logic [SEL_W-1:0] s);
    ratio_cfg_t c;
    c.vld = 1'b1;
    case (s)
      3'd0:    begin c.p_half = 3'd4; c.b_half = 3'd4; c.per = 5'd8;  end
      3'd1:    begin c.p_half = 3'd3; c.b_half = 3'd4; c.per = 5'd24; end
      3'd2:    begin c.p_half = 3'd2; c.b_half = 3'd3; c.per = 5'd12; end
      3'd3:    begin c.p_half = 3'd3; c.b_half = 3'd5; c.per = 5'd30; end
      3'd4:    begin c.p_half = 3'd2; c.b_half = 3'd4; c.per = 5'd8;  end
      3'd5:    begin c.p_half = 3'd3; c.b_half = 3'd3; c.per = 5'd6;  end
      3'd6:    begin c.p_half = 3'd5; c.b_half = 3'd5; c.per = 5'd10; end
      default: begin c.vld = 1'b0; c.p_half = 3'd1; c.b_half = 3'd1; c.per = 5'd1; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/half_div.sv
module half_div #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         start_en_i,
  input  logic [W-1:0] half_i,
  output logic         clk_o
);
  logic [W-1:0] cnt_q;
  logic         q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q     <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      q     <= start_en_i;
    end else if (cnt_q == half_i - 1'b1) begin
      cnt_q <= '0;
      q     <= ~q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = q;
endmodule

// File: rtl/period_ctl.sv
module period_ctl
  import ratio_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             restart_o,
  output logic             start_en_o,
  output ratio_cfg_t       cfg_o,
  output logic             sync_o,
  output logic             bad_o
);
  localparam int PAD_W = PER_W - HALF_W - 1;

  ratio_cfg_t       cfg_q, nxt;
  logic             run_q, sync_q, bad_q;
  logic [PER_W-1:0] per_q, p_len;

  assign nxt       = decode_sel(sel_i);
  assign p_len     = {{PAD_W{1'b0}}, cfg_q.p_half, 1'b0};
  assign restart_o = !run_q || (per_q == cfg_q.per - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      per_q  <= '0;
      cfg_q  <= '0;
      sync_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (restart_o) begin
      run_q  <= 1'b1;
      per_q  <= '0;
      cfg_q  <= nxt;
      sync_q <= nxt.vld;
      bad_q  <= !nxt.vld;
    end else begin
      per_q <= per_q + 1'b1;
      if (per_q == p_len - 1'b1) sync_q <= 1'b0;
    end
  end

  assign start_en_o = nxt.vld;
  assign cfg_o      = cfg_q;
  assign sync_o     = sync_q;
  assign bad_o      = bad_q;
endmodule

// File: rtl/ratio_clk_gen.sv
module ratio_clk_gen
  import ratio_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pclk_o,
  output logic             bclk_o,
  output logic             sync_o,
  output logic             bad_sel_o
);
  ratio_cfg_t cfg;
  logic       restart, start_en;
  logic [HALF_W-1:0] half [2];
  logic [1:0]        outs;

  period_ctl u_ctl (
    .clk_i, .rst_ni, .sel_i,
    .restart_o(restart), .start_en_o(start_en), .cfg_o(cfg),
    .sync_o, .bad_o(bad_sel_o)
  );

  assign half[0] = cfg.p_half;
  assign half[1] = cfg.b_half;

  for (genvar i = 0; i < 2; i++) begin : g_div
    half_div #(.W(HALF_W)) u_div (
      .clk_i, .rst_ni,
      .restart_i(restart), .start_en_i(start_en),
      .half_i(half[i]), .clk_o(outs[i])
    );
  end

  assign pclk_o = outs[0];
  assign bclk_o = outs[1];
endmodule

// File: rtl/ratio_clk_gen_chk.sv
module ratio_clk_gen_chk
  import ratio_clk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pclk_i,
  input logic       bclk_i,
  input logic       sync_i,
  input logic       bad_i,
  input logic       restart_i,
  input ratio_cfg_t cfg_i
);
  AST_INVALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |-> (!pclk_i && !bclk_i && !sync_i)); // R6
  AST_SYNC_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_i) |-> ($rose(pclk_i) && $rose(bclk_i))); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> $stable(cfg_i)); // R5
  AST_PCLK_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_i) |=> pclk_i); // R2
  AST_BCLK_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_i) |=> bclk_i); // R2
  AST_VALID_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pclk_i || bclk_i) |-> !bad_i); // R7
endmodule

bind ratio_clk_gen ratio_clk_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pclk_o), .bclk_i(bclk_o),
  .sync_i(sync_o), .bad_i(bad_sel_o), .restart_i(restart), .cfg_i(cfg)
);

// File: tb/ratio_clk_gen_test.sv
module ratio_clk_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       pclk_o, bclk_o, sync_o, bad_sel_o;

  int checks = 0, errors = 0;
  int cur = 0, phase = 0;
  bit started = 0, done = 0;

  ratio_clk_gen uut (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic int pdiv(int s);
    case (s) 0: return 8; 1: return 6; 2: return 4; 3: return 6;
             4: return 4; 5: return 6; 6: return 10; default: return 0; endcase
  endfunction
  function automatic int bdiv(int s);
    case (s) 0: return 8; 1: return 8; 2: return 6; 3: return 10;
             4: return 8; 5: return 6; 6: return 10; default: return 0; endcase
  endfunction
  function automatic int lcm(int a, int b);
    int x = a, y = b, t;
    if (a == 0) return 1;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return a / x * b;
  endfunction

  task automatic chk(string req, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s sel=%0d phase=%0d: got %b expected %b", req, name, cur, phase, act, exp);
    end
  endtask

  task automatic step(string tp, string tb, string ts, string tf);
    int p, b;
    bit v;
    @(posedge clk_i);
    if (rst_ni) begin
      if (!started || phase == lcm(pdiv(cur), bdiv(cur)) - 1) begin
        cur = int'(sel_i); phase = 0; started = 1;
      end else phase++;
    end
    @(negedge clk_i);
    p = pdiv(cur); b = bdiv(cur); v = (cur != 7);
    chk(tp, "pclk", pclk_o, v && ((phase % (v ? p : 1)) < p / 2));
    chk(tb, "bclk", bclk_o, v && ((phase % (v ? b : 1)) < b / 2));
    chk(ts, "sync", sync_o, v && (phase < p));
    chk(tf, "bad",  bad_sel_o, !v);
  endtask

  task automatic do_reset(int s);
    @(negedge clk_i);
    rst_ni = 1'b0; sel_i = 3'(s); started = 0;
    @(negedge clk_i);
    chk("R3", "pclk_rst", pclk_o, 1'b0);
    chk("R3", "bclk_rst", bclk_o, 1'b0);
    chk("R3", "sync_rst", sync_o, 1'b0);
    chk("R3", "bad_rst",  bad_sel_o, 1'b0);
    rst_ni = 1'b1;
    step("R3", "R3", "R3", s == 7 ? "R6" : "R7");
  endtask

  task automatic run(int n, string tp, string tb, string ts, string tf);
    for (int i = 0; i < n; i++) step(tp, tb, ts, tf);
  endtask

  initial begin
    // R1 R2 R4 R6 R7: sweep of every select from reset
    for (int s = 0; s < 8; s++) begin
      do_reset(s);
      run(70, "R1", "R2", "R4", s == 7 ? "R6" : "R7");
    end
    // R5: mid-period select changes wait for the boundary
    for (int a = 0; a < 7; a++) begin
      do_reset(a);
      run(5, "R5", "R5", "R5", "R5");
      sel_i = 3'((a + 3) % 7);
      run(75, "R5", "R5", "R5", "R5");
    end
    do_reset(3);
    run(7, "R5", "R5", "R5", "R5");
    sel_i = 3'd7;
    run(40, "R5", "R5", "R5", "R6");
    // R6: leaving the unsupported select
    do_reset(7);
    run(4, "R6", "R6", "R6", "R6");
    sel_i = 3'd0;
    run(20, "R6", "R6", "R6", "R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule